// File: doc/BRIEF.md
# Sequential Fixed-Point Restoring Divider

This block divides an unsigned 16-bit dividend by an unsigned 14-bit divisor. It returns an unsigned quotient in Q16.16 form: 16 integer bits above 16 fractional bits. The dividend is padded with 16 zero bits below its least significant bit. The block then runs restoring division on the 32-bit result of that padding. Each clock cycle produces one quotient bit, starting at the most significant bit. The partial remainder is one bit wider than the divisor.

A controller with three states sequences the work:

- `ST_IDLE` waits for `start`. On that edge it captures both operands, clears the partial remainder and the quotient, and moves to `ST_RUN` (transition *accept*).
- `ST_RUN` makes one trial subtraction per cycle. It stays in this state until the step counter reaches its last value (transition *iterate*), then moves to `ST_FINISH` (transition *last step*).
- `ST_FINISH` raises `done` for one cycle and always returns to `ST_IDLE` (transition *retire*).

A divisor of zero raises `div_by_zero`. It drives every quotient bit to one and keeps the same latency.

Top module: `fxdiv_restoring`

## Requirements
- R1: After reset, `done` and `div_by_zero` are 0 and `quotient` is all zeros.
- R2: For a nonzero divisor, `quotient` equals floor(dividend * 65536 / divisor). Bits 31..16 hold the integer part and bits 15..0 the fraction.
- R3: Take the rising edge at which `start` is accepted as edge 0. `done` is high in the cycle that follows edge 32, and for that one cycle only.
- R4: With a divisor of zero, `div_by_zero` is 1 when `done` is high, `quotient` is 0xFFFFFFFF, and the latency is the same as in R3.
- R5: With a nonzero divisor, `div_by_zero` is 0 when `done` is high, even when the previous division had a zero divisor.
- R6: The operands are captured at the accepting edge. A `start` that arrives while a division is in progress has no effect, and neither do changes to the operand inputs during that time.
- R7: After `done`, `quotient` and `div_by_zero` keep their values until the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only when idle |
| dividend | input | 16 | Unsigned dividend |
| divisor | input | 14 | Unsigned divisor |
| done | output | 1 | One-cycle pulse: the result is ready |
| quotient | output | 32 | Unsigned Q16.16 quotient |
| div_by_zero | output | 1 | The divisor of the last accepted operation was zero |

## Verification
The assertions check the following on every cycle:

- the exact start-to-done latency and the single-cycle width of `done`;
- that the result stays stable while idle;
- the all-ones result under a zero divisor;
- that the captured divisor cannot change while busy;
- that the partial remainder stays below a nonzero divisor.

Only the bench scenarios can show that the quotient value is arithmetically correct. They compare it with a floor division computed in the bench, over boundary operands (divisor 1, the largest divisor, the largest dividend, a zero dividend) and random operands. They also show that a second `start`, and operand changes during a running division, leave the result untouched.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } fx_state_e;

endpackage

// File: rtl/fxdiv_ctrl.sv
module fxdiv_ctrl
    import fxdiv_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output logic      load,
    output logic      step,
    output logic      done_o,
    output fx_state_e state_o
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    fx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_RUN;               // accept
            ST_RUN:    if (cnt_q == LAST) state_d = ST_FINISH;    // last step / iterate
            ST_FINISH: state_d = ST_IDLE;                         // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE)
                cnt_q <= '0;
            else if (state_q == ST_RUN)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   load   = start;
            ST_RUN:    step   = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/fxdiv_core.sv
module fxdiv_core #(
    parameter int DVD_W  = 16,
    parameter int DSR_W  = 14,
    parameter int FRAC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [DVD_W-1:0]         dividend,
    input  logic [DSR_W-1:0]         divisor,
    output logic [DVD_W+FRAC_W-1:0]  quo_o,
    output logic                     dbz_o,
    output logic [DSR_W:0]           rem_o,
    output logic [DSR_W-1:0]         dsr_o
);

    localparam int EXT_W = DVD_W + FRAC_W;
    localparam int REM_W = DSR_W + 1;

    logic [EXT_W-1:0] ext_dvd;
    logic [EXT_W-1:0] dvd_q;
    logic [EXT_W-1:0] quo_q;
    logic [REM_W-1:0] rem_q;
    logic [DSR_W-1:0] dsr_q;
    logic             dbz_q;
    logic [REM_W-1:0] trial;
    logic             fits;

    // scale the dividend by 2^FRAC_W (variant chosen by parameter)
    generate
        if (FRAC_W > 0) begin : g_scaled
            assign ext_dvd = {dividend, {FRAC_W{1'b0}}};
        end else begin : g_plain
            assign ext_dvd = dividend;
        end
    endgenerate

    // one restoring step: shift in next dividend bit, trial-subtract
    assign trial = {rem_q[REM_W-2:0], dvd_q[EXT_W-1]};
    assign fits  = (trial >= {1'b0, dsr_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            dbz_q <= 1'b0;
        end else if (load) begin
            dvd_q <= ext_dvd;
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= divisor;
            dbz_q <= (divisor == '0);
        end else if (step) begin
            dvd_q <= {dvd_q[EXT_W-2:0], 1'b0};
            quo_q <= {quo_q[EXT_W-2:0], fits};
            rem_q <= fits ? (trial - {1'b0, dsr_q}) : trial;
        end
    end

    assign quo_o = quo_q;
    assign dbz_o = dbz_q;
    assign rem_o = rem_q;
    assign dsr_o = dsr_q;

endmodule

// File: rtl/fxdiv_restoring.sv
module fxdiv_restoring
    import fxdiv_pkg::*;
#(
    parameter int DVD_W  = 16,
    parameter int DSR_W  = 14,
    parameter int FRAC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DVD_W-1:0]        dividend,
    input  logic [DSR_W-1:0]        divisor,
    output logic                    done,
    output logic [DVD_W+FRAC_W-1:0] quotient,
    output logic                    div_by_zero
);

    localparam int EXT_W = DVD_W + FRAC_W;

    logic             load;
    logic             step;
    fx_state_e        st;
    logic [DSR_W:0]   part_rem;
    logic [DSR_W-1:0] dsr_q;

    fxdiv_ctrl #(
        .STEPS (EXT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step    (step),
        .done_o  (done),
        .state_o (st)
    );

    fxdiv_core #(
        .DVD_W  (DVD_W),
        .DSR_W  (DSR_W),
        .FRAC_W (FRAC_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .dividend (dividend),
        .divisor  (divisor),
        .quo_o    (quotient),
        .dbz_o    (div_by_zero),
        .rem_o    (part_rem),
        .dsr_o    (dsr_q)
    );

endmodule

// File: rtl/fxdiv_checker.sv
module fxdiv_checker
    import fxdiv_pkg::*;
#(
    parameter int DSR_W = 14,
    parameter int EXT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [EXT_W-1:0] quotient,
    input logic             dbz,
    input fx_state_e        state,
    input logic [DSR_W:0]   rem,
    input logic [DSR_W-1:0] dsr
);

    localparam int LAT_W = $clog2(EXT_W + 2) + 1;
    localparam logic [LAT_W-1:0] LAT_DONE = LAT_W'(EXT_W + 1);

    logic [LAT_W-1:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat <= '0;
        else if (start && state == ST_IDLE)
            lat <= LAT_W'(1);
        else if (done)
            lat <= '0;
        else if (lat != '0)
            lat <= lat + 1'b1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == LAT_DONE)); // R3
    AST_DONE_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (lat == LAT_DONE) |-> done); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DBZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbz) |-> (quotient == '1)); // R4
    AST_BUSY_HOLDS_DSR: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(dsr)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(quotient) && $stable(dbz))); // R7
    AST_REM_BELOW_DSR: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && dsr != '0) |-> (rem < {1'b0, dsr})); // R2

endmodule

bind fxdiv_restoring fxdiv_checker #(
    .DSR_W (DSR_W),
    .EXT_W (EXT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .quotient (quotient),
    .dbz      (div_by_zero),
    .state    (st),
    .rem      (part_rem),
    .dsr      (dsr_q)
);

// File: tb/fxdiv_restoring_test.sv
module fxdiv_restoring_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [13:0] divisor = '0;
    logic        done;
    logic [31:0] quotient;
    logic        div_by_zero;

    int checks = 0;
    int errors = 0;

    fxdiv_restoring uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .done        (done),
        .quotient    (quotient),
        .div_by_zero (div_by_zero)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_quo(input logic [15:0] a, input logic [13:0] b);
        logic [63:0] num;
        num = {32'd0, a, 16'd0};
        if (b == 14'd0) return 32'hFFFF_FFFF;
        return 32'(num / {50'd0, b});
    endfunction

    // launch a division; optionally disturb it at cycle 5; return cycles to done
    task automatic run_div(input logic [15:0] a, input logic [13:0] b,
                           input bit disturb, output int lat);
        lat = -1;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int m = 1; m <= 40; m++) begin
            @(negedge clk);
            if (disturb && m == 5) begin
                start = 1'b1; dividend = ~a; divisor = b ^ 14'h155;
            end else if (disturb && m == 6) begin
                start = 1'b0;
            end
            if (done && lat < 0) lat = m;
            if (lat > 0) break;
        end
    endtask

    task automatic do_check(input logic [15:0] a, input logic [13:0] b, input string tag);
        int lat;
        run_div(a, b, 1'b0, lat);
        check(lat == 32, "R3", 64'(lat), 64'd32);
        check(quotient == ref_quo(a, b), tag, 64'(quotient), 64'(ref_quo(a, b)));
        check(div_by_zero == (b == 14'd0), (b == 0) ? "R4" : "R5", 64'(div_by_zero), 64'(b == 0));
        @(negedge clk);
        check(!done, "R3", 64'(done), 64'd0);
    endtask

    task automatic test_reset();
        check(done == 1'b0, "R1", 64'(done), 64'd0);
        check(quotient == 32'd0, "R1", 64'(quotient), 64'd0);
        check(div_by_zero == 1'b0, "R1", 64'(div_by_zero), 64'd0);
    endtask

    task automatic test_boundaries();
        do_check(16'd1, 14'd1, "R2");
        do_check(16'hFFFF, 14'd1, "R2");
        do_check(16'hFFFF, 14'h3FFF, "R2");
        do_check(16'd1, 14'h3FFF, "R2");
        do_check(16'd0, 14'd5, "R2");
        do_check(16'd1, 14'd3, "R2");
        do_check(16'd100, 14'd7, "R2");
    endtask

    task automatic test_random();
        for (int i = 0; i < 20; i++) begin
            logic [15:0] a;
            logic [13:0] b;
            a = 16'($urandom);
            b = 14'($urandom);
            if (b == 14'd0) b = 14'd9;
            do_check(a, b, "R2");
        end
    endtask

    task automatic test_zero_divisor();
        do_check(16'd1234, 14'd0, "R4");
        do_check(16'd1234, 14'd10, "R5");   // flag clears after a zero-divisor run
    endtask

    task automatic test_busy_start();
        int lat;
        run_div(16'd5000, 14'd3, 1'b1, lat);
        check(lat == 32, "R6", 64'(lat), 64'd32);
        check(quotient == ref_quo(16'd5000, 14'd3), "R6", 64'(quotient), 64'(ref_quo(16'd5000, 14'd3)));
    endtask

    task automatic test_hold();
        logic [31:0] q0;
        do_check(16'd777, 14'd13, "R2");
        q0 = quotient;
        dividend = 16'h1111; divisor = 14'd0;
        repeat (4) @(negedge clk);
        check(quotient == q0, "R7", 64'(quotient), 64'(q0));
        check(div_by_zero == 1'b0, "R7", 64'(div_by_zero), 64'd0);
        check(!done, "R7", 64'(done), 64'd0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_boundaries();
        test_zero_divisor();
        test_busy_start();
        test_hold();
        test_random();
        summary();
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule